// File: doc/BRIEF.md
# Clock-Presence Power-Down Controller

This block is the control logic that sits next to a clock-distribution PLL. It measures how fast the monitored input clock runs by counting its rising edges over a fixed window of a free-running reference clock. It combines that measurement with a power-on request and a bypass strap. From these inputs it drives four controls: the PLL enable, a single output enable for every clock output pair (the feedback pair included), a select that routes the raw input instead of the PLL to the outputs, and a ready flag that rises once a freshly enabled PLL has had time to lock.

The frequency decision has hysteresis. A window with fewer than `LO_EDGES` edges declares the input too slow, and the block falls back to the same low-power state as a power-down. Operation resumes only after a window counts at least `HI_EDGES` edges. Counts between the two thresholds keep the previous decision. Whenever the PLL is switched on, the outputs stay high-impedance for `LOCK_CYC` reference cycles before they are enabled. When the bypass strap is set, the PLL stays off and the input drives the outputs directly, provided power is on and the input is fast enough.

Every control input (`power_on`, `bypass_strap`, `rst`) is synchronous to `ref_clk`. The monitored clock is asynchronous to it and passes through a toggle and a synchronizer chain before its edges are counted.

Top module: `clk_presence_pd`

## Requirements
- R1: After a synchronous reset (`rst` high on a `ref_clk` edge) all four outputs `pll_en`, `out_en`, `sel_bypass` and `ready` are 0, even if `power_on` is already high.
- R2: While `power_on` is low, at the first `ref_clk` edge all four outputs become 0, whatever the state was before.
- R3: When `power_on` is high, the strap is low and a window counts at least `HI_EDGES` monitored edges, the block turns the PLL on and reaches the running state (`pll_en`=1, `out_en`=1, `sel_bypass`=0, `ready`=1).
- R4: A window with fewer than `LO_EDGES` monitored edges, including a stopped clock, drives all four outputs to 0.
- R5: A window whose count lies between `LO_EDGES` and `HI_EDGES`-1 leaves the running-or-off decision unchanged.
- R6: After `pll_en` rises, `out_en` and `ready` stay 0 for exactly `LOCK_CYC` reference cycles and then rise together.
- R7: With the strap high, `power_on` high and the input fast enough, the outputs are `pll_en`=0, `out_en`=1, `sel_bypass`=1, `ready`=0.
- R8: Releasing the strap drops all outputs to 0 for one cycle and then starts a fresh lock wait of `LOCK_CYC` cycles.
- R9: `out_en` is high exactly when `ready` or `sel_bypass` is high, and `pll_en` is never high together with `sel_bypass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all control logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored input clock, asynchronous to `ref_clk` |
| power_on | input | 1 | 1 requests operation, 0 forces the low-power state |
| bypass_strap | input | 1 | 1 holds the PLL off and routes the input straight to the outputs |
| pll_en | output | 1 | Enables the PLL |
| out_en | output | 1 | Drives all clock output pairs and the feedback pair; 0 means high-impedance |
| sel_bypass | output | 1 | 1 selects the raw input clock for the outputs |
| ready | output | 1 | PLL treated as locked and outputs running from it |

## Verification
A change on `power_on` or `bypass_strap` applied between edges shows on the outputs one `ref_clk` edge later. The bench drives those inputs at a falling edge and checks the outputs at the next falling edge. The lock wait is measured exactly: the bench counts the falling edges from the first sample where `pll_en` is high to the first sample where `ready` is high, and expects `LOCK_CYC`. A frequency change takes effect only after a window closes, and the exact cycle also depends on synchronizer phase. Frequency checks are therefore made only after 600 cycles of settling, which covers several windows plus the lock wait. The expected outputs for these checks come from a bench model of the hysteresis and the state priorities.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WAIT   = 2'd1,
        ST_RUN    = 2'd2,
        ST_BYPASS = 2'd3
    } cpd_state_e;

    typedef enum logic [1:0] {
        FR_SLOW = 2'd0,
        FR_MID  = 2'd1,
        FR_FAST = 2'd2
    } freq_class_e;

    typedef struct packed {
        logic pll_en;
        logic out_en;
        logic sel_bypass;
        logic ready;
    } cpd_ctrl_t;

    function automatic freq_class_e classify(input int unsigned total,
                                             input int unsigned lo,
                                             input int unsigned hi);
        if (total < lo)       return FR_SLOW;
        else if (total >= hi) return FR_FAST;
        else                  return FR_MID;
    endfunction

    function automatic cpd_state_e next_state(input cpd_state_e cur,
                                              input logic power_on,
                                              input logic strap,
                                              input logic freq_ok,
                                              input logic lock_done);
        cpd_state_e nxt;
        nxt = cur;
        if (!power_on || !freq_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (cur)
                ST_OFF:    nxt = strap ? ST_BYPASS : ST_WAIT;
                ST_WAIT:   nxt = strap ? ST_BYPASS : (lock_done ? ST_RUN : ST_WAIT);
                ST_RUN:    nxt = strap ? ST_BYPASS : ST_RUN;
                ST_BYPASS: nxt = strap ? ST_BYPASS : ST_OFF;
                default:   nxt = ST_OFF;
            endcase
        end
        return nxt;
    endfunction

    function automatic cpd_ctrl_t decode(input cpd_state_e st);
        cpd_ctrl_t c;
        c.pll_en     = (st == ST_WAIT) || (st == ST_RUN);
        c.out_en     = (st == ST_RUN)  || (st == ST_BYPASS);
        c.sel_bypass = (st == ST_BYPASS);
        c.ready      = (st == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/cpd_edge_sync.sv
module cpd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic ref_clk,
    input  logic rst,
    output logic edge_pulse
);
    logic                   tog;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge mon_clk) begin
        if (rst) tog <= 1'b0;
        else     tog <= ~tog;
    end

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge ref_clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= tog;
                end
            end else begin : g_next
                always_ff @(posedge ref_clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge ref_clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_pulse = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/cpd_freq_meter.sv
module cpd_freq_meter
    import cpd_pkg::*;
#(
    parameter int WIN_CYC  = 64,
    parameter int LO_EDGES = 5,
    parameter int HI_EDGES = 10
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic edge_pulse,
    output logic freq_ok
);
    localparam int WW = $clog2(WIN_CYC);
    localparam int EW = $clog2(WIN_CYC + 1);

    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] total;
    logic          win_end;
    freq_class_e   cls;

    assign win_end = (win_cnt == WW'(WIN_CYC - 1));
    assign total   = edge_cnt + EW'(edge_pulse);
    assign cls     = classify(32'(total), LO_EDGES, HI_EDGES);

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            freq_ok  <= 1'b0;
        end else if (win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
            if (cls == FR_FAST)      freq_ok <= 1'b1;
            else if (cls == FR_SLOW) freq_ok <= 1'b0;
        end else begin
            win_cnt  <= win_cnt + 1'b1;
            edge_cnt <= total;
        end
    end

    p_fast_sets_r3: assert property (@(posedge ref_clk) disable iff (rst)
        (win_end && (32'(total) >= HI_EDGES)) |=> freq_ok);
    p_slow_clears_r4: assert property (@(posedge ref_clk) disable iff (rst)
        (win_end && (32'(total) < LO_EDGES)) |=> !freq_ok);
    p_hold_r5: assert property (@(posedge ref_clk) disable iff (rst)
        (!win_end || cls == FR_MID) |=> $stable(freq_ok));

endmodule

// File: rtl/cpd_lock_timer.sv
module cpd_lock_timer #(
    parameter int LOCK_CYC = 200
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int LW = $clog2(LOCK_CYC);

    logic [LW-1:0] cnt;

    always_ff @(posedge ref_clk) begin
        if (rst || !run) cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LW'(LOCK_CYC - 1));

    p_done_needs_run_r6: assert property (@(posedge ref_clk) disable iff (rst)
        done |-> $past(run));

endmodule

// File: rtl/cpd_fsm.sv
module cpd_fsm
    import cpd_pkg::*;
#(
    parameter int LOCK_CYC = 200
) (
    input  logic       ref_clk,
    input  logic       rst,
    input  logic       power_on,
    input  logic       bypass_strap,
    input  logic       freq_ok,
    input  logic       lock_done,
    output cpd_state_e state,
    output cpd_ctrl_t  ctrl
);
    always_ff @(posedge ref_clk) begin
        if (rst) state <= ST_OFF;
        else     state <= next_state(state, power_on, bypass_strap, freq_ok, lock_done);
    end

    assign ctrl = decode(state);

    int wait_len;
    always_ff @(posedge ref_clk) begin
        if (rst || state != ST_WAIT) wait_len <= 0;
        else                         wait_len <= wait_len + 1;
    end

    p_pwr_off_r2: assert property (@(posedge ref_clk) disable iff (rst)
        !power_on |=> (state == ST_OFF));
    p_slow_off_r4: assert property (@(posedge ref_clk) disable iff (rst)
        !freq_ok |=> !ctrl.out_en);
    p_wait_len_r6: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(ctrl.ready) |-> (wait_len == LOCK_CYC));
    p_bypass_entry_r7: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(ctrl.sel_bypass) |-> $past(bypass_strap && power_on));
    p_release_off_r8: assert property (@(posedge ref_clk) disable iff (rst)
        (state == ST_BYPASS && !bypass_strap) |=> (state == ST_OFF));

endmodule

// File: rtl/clk_presence_pd.sv
module clk_presence_pd
    import cpd_pkg::*;
#(
    parameter int WIN_CYC     = 64,
    parameter int LO_EDGES    = 5,
    parameter int HI_EDGES    = 10,
    parameter int LOCK_CYC    = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic mon_clk,
    input  logic power_on,
    input  logic bypass_strap,
    output logic pll_en,
    output logic out_en,
    output logic sel_bypass,
    output logic ready
);
    logic       edge_pulse;
    logic       freq_ok;
    logic       lock_done;
    cpd_state_e state;
    cpd_ctrl_t  ctrl;

    cpd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .mon_clk    (mon_clk),
        .ref_clk    (ref_clk),
        .rst        (rst),
        .edge_pulse (edge_pulse)
    );

    cpd_freq_meter #(
        .WIN_CYC  (WIN_CYC),
        .LO_EDGES (LO_EDGES),
        .HI_EDGES (HI_EDGES)
    ) u_meter (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .edge_pulse (edge_pulse),
        .freq_ok    (freq_ok)
    );

    cpd_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .ref_clk (ref_clk),
        .rst     (rst),
        .run     (state == ST_WAIT),
        .done    (lock_done)
    );

    cpd_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
        .ref_clk      (ref_clk),
        .rst          (rst),
        .power_on     (power_on),
        .bypass_strap (bypass_strap),
        .freq_ok      (freq_ok),
        .lock_done    (lock_done),
        .state        (state),
        .ctrl         (ctrl)
    );

    assign pll_en     = ctrl.pll_en;
    assign out_en     = ctrl.out_en;
    assign sel_bypass = ctrl.sel_bypass;
    assign ready      = ctrl.ready;

    p_oe_source_r9: assert property (@(posedge ref_clk) disable iff (rst)
        out_en |-> (ready || sel_bypass));
    p_pll_vs_bypass_r9: assert property (@(posedge ref_clk) disable iff (rst)
        !(pll_en && sel_bypass));

endmodule

// File: tb/clk_presence_pd_tb_top.sv
module clk_presence_pd_tb_top;
    localparam int LOCK_CYC = 200;
    localparam int SETTLE   = 600;

    logic ref_clk = 1'b0;
    logic rst = 1'b1;
    logic mon_clk = 1'b0;
    logic power_on = 1'b0;
    logic bypass_strap = 1'b0;
    logic pll_en, out_en, sel_bypass, ready;

    int checks = 0;
    int errors = 0;
    int mon_half = 12;
    bit done_flag = 0;
    bit model_fok = 0;

    always #4 ref_clk = ~ref_clk;

    always begin
        if (mon_half == 0) begin
            mon_clk = 1'b0;
            #8;
        end else begin
            #(mon_half) mon_clk = ~mon_clk;
        end
    end

    clk_presence_pd dut_i (
        .ref_clk      (ref_clk),
        .rst          (rst),
        .mon_clk      (mon_clk),
        .power_on     (power_on),
        .bypass_strap (bypass_strap),
        .pll_en       (pll_en),
        .out_en       (out_en),
        .sel_bypass   (sel_bypass),
        .ready        (ready)
    );

    function automatic logic [3:0] expect_outs(input bit pwr, input bit strap, input bit fok);
        if (!pwr || !fok) return 4'b0000;
        if (strap)        return 4'b0110;
        return 4'b1101;
    endfunction

    task automatic check_outs(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pll_en, out_en, sel_bypass, ready};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {pll_en,out_en,sel,ready} = %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic measure_lock(input string tag);
        int n;
        int guard;
        guard = 0;
        while (!pll_en && guard < 2000) begin
            @(negedge ref_clk);
            guard++;
        end
        check_val({tag, " pll_en rises"}, int'(pll_en), 1);
        check_val({tag, " outputs off during wait"}, int'(out_en | ready), 0);
        n = 0;
        while (!ready && n < 4 * LOCK_CYC) begin
            @(negedge ref_clk);
            n++;
        end
        check_val({tag, " lock wait length"}, n, LOCK_CYC);
        check_val({tag, " out_en with ready"}, int'(out_en), 1);
    endtask

    initial begin
        repeat (200000) @(posedge ref_clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        power_on = 1'b1;
        cyc(10);
        rst = 1'b0;
        @(negedge ref_clk);
        check_outs("R1 reset state", 4'b0000);

        // R6 / R3: first start-up
        measure_lock("R6 first start");
        check_outs("R3 running", 4'b1101);
        model_fok = 1;

        // R2: power off from RUN
        power_on = 1'b0;
        @(negedge ref_clk);
        check_outs("R2 power off", 4'b0000);
        power_on = 1'b1;
        cyc(SETTLE);
        check_outs("R3 rerun", 4'b1101);

        // R7: bypass entry
        bypass_strap = 1'b1;
        @(negedge ref_clk);
        check_outs("R7 bypass", 4'b0110);
        // R2 from bypass
        power_on = 1'b0;
        @(negedge ref_clk);
        check_outs("R2 power off in bypass", 4'b0000);
        power_on = 1'b1;
        cyc(3);
        check_outs("R7 bypass again", 4'b0110);

        // R8: strap release
        bypass_strap = 1'b0;
        @(negedge ref_clk);
        check_outs("R8 release off", 4'b0000);
        measure_lock("R8 relock");

        // R4 / R5 hysteresis
        mon_half = 100;
        cyc(SETTLE);
        check_outs("R4 slow input", 4'b0000);
        mon_half = 32;
        cyc(SETTLE);
        check_outs("R5 mid holds off", 4'b0000);
        mon_half = 12;
        cyc(SETTLE);
        check_outs("R3 fast resumes", 4'b1101);
        mon_half = 32;
        cyc(SETTLE);
        check_outs("R5 mid holds run", 4'b1101);
        mon_half = 0;
        cyc(SETTLE);
        check_outs("R4 stopped clock", 4'b0000);
        model_fok = 0;

        // random mix
        void'($urandom(32'd1234));
        for (int it = 0; it < 24; it++) begin
            int f;
            bit p;
            bit s;
            f = $urandom_range(0, 2);
            p = ($urandom_range(0, 3) != 0);
            s = ($urandom_range(0, 2) == 0);
            mon_half = (f == 0) ? 100 : ((f == 1) ? 32 : 12);
            power_on = p;
            bypass_strap = s;
            if (f == 0) model_fok = 0;
            else if (f == 2) model_fok = 1;
            cyc(SETTLE);
            check_outs(f == 1 ? "R5 random" : (s ? "R7 random" : "R3 random"),
                       expect_outs(p, s, model_fok));
            check_val("R9 out_en source", int'(out_en), int'(ready | sel_bypass));
        end

        done_flag = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule